// File: doc/BRIEF.md
# Selectable-Tap Base Timer

A 14-bit free-running counter for time-of-day and periodic housekeeping work. On each cycle of the core clock the counter may advance by one; whether it does is decided by one of three single-cycle advance strobes (a 32.768 kHz crystal tick, the system cycle strobe, or the general timer's prescaler output), chosen by a 2-bit source select, and by a run enable.

Two sticky interrupt flags come out. The long flag rises each time the counter rolls from 16383 to 0, which at 32.768 kHz is every half second. The short flag rises each time the low bits selected by a 2-bit tap select roll over, giving periods of 32, 128, 512 or 2048 advances (about 1 ms, 3.9 ms, 15.6 ms and 62.5 ms from the crystal). Each flag has its own enable and its own clear strobe; a counter clear restarts the count without raising either flag. In a system the long flag shares an interrupt vector with an external interrupt line.

Top module: `clkkeep_base_timer`

## Requirements
- R1: After reset the counter is zero and both flags read 0.
- R2: The source select picks the advance strobe: 00 crystal tick, 01 system strobe, 10 prescaler strobe, 11 none; strobes on unselected lines do not advance the counter.
- R3: With the long enable high, the long flag rises on the clock edge of the 16384th advance counted from zero.
- R4: With the short enable high, the short flag rises on the edge of advance number 32, 128, 512 or 2048 counted from zero, for tap select 00, 01, 10 and 11 respectively, and after every further such span.
- R5: A flag whose enable is low does not rise on its event.
- R6: A flag stays 1 until its clear strobe is high at an edge; if its event and its clear coincide, the flag ends 1.
- R7: The counter clear sets the counter to zero at the next edge, takes priority over an advance in the same cycle, and raises no flag.
- R8: The counter wraps from 16383 to 0 and keeps running, so the long flag rises again after each further 16384 advances.
- R9: While the run enable is low the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xtal_tick | input | 1 | Crystal advance strobe, one cycle wide |
| sys_tick | input | 1 | System cycle advance strobe |
| pre_tick | input | 1 | General timer prescaler advance strobe |
| src_sel | input | 2 | Advance source select (see R2) |
| tap_sel | input | 2 | Short period select (see R4) |
| run | input | 1 | Counting enable |
| wrap_ie | input | 1 | Long flag enable |
| tap_ie | input | 1 | Short flag enable |
| count_clr | input | 1 | Synchronous counter clear |
| wrap_flag_clr | input | 1 | Long flag clear strobe |
| tap_flag_clr | input | 1 | Short flag clear strobe |
| wrap_flag | output | 1 | Sticky long-period flag |
| tap_flag | output | 1 | Sticky short-period flag |

## Verification
The counter is not visible at the ports, so a wrong count shows only as a flag edge on the wrong advance: one advance early or late at the short tap is seen within 2048 advances at most, while a fault confined to the upper bits only appears at the long flag after up to 16384 advances. The bench therefore counts advances exactly from a cleared counter and samples the flags one advance before and exactly at each expected rollover. A mis-routed source select or a clear that leaks a flag is caught immediately at the next tap boundary.

// File: rtl/clkkeep_base_timer.sv
module clkkeep_base_timer #(
  parameter int CNT_W    = 14,
  parameter int TAP_LSB  = 5,
  parameter int TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_tick,
  input  logic       sys_tick,
  input  logic       pre_tick,
  input  logic [1:0] src_sel,
  input  logic [1:0] tap_sel,
  input  logic       run,
  input  logic       wrap_ie,
  input  logic       tap_ie,
  input  logic       count_clr,
  input  logic       wrap_flag_clr,
  input  logic       tap_flag_clr,
  output logic       wrap_flag,
  output logic       tap_flag
);
  localparam int NTAP = 4;

  logic [CNT_W-1:0] cnt;
  logic [NTAP-1:0]  tap_hit;
  logic             src_tick, adv, wrap_evt, tap_evt;

  always_comb begin
    case (src_sel)
      2'b00:   src_tick = xtal_tick;
      2'b01:   src_tick = sys_tick;
      2'b10:   src_tick = pre_tick;
      default: src_tick = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap_hit[i] = &cnt[TAP_LSB+TAP_STEP*i-1:0];
  end

  assign adv      = run & src_tick & ~count_clr;
  assign wrap_evt = adv & (&cnt);
  assign tap_evt  = adv & tap_hit[tap_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (count_clr) cnt <= '0;
    else if (adv)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_flag <= 1'b0;
      tap_flag  <= 1'b0;
    end else begin
      wrap_flag <= (wrap_flag & ~wrap_flag_clr) | (wrap_evt & wrap_ie);
      tap_flag  <= (tap_flag & ~tap_flag_clr) | (tap_evt & tap_ie);
    end
  end
endmodule

// File: rtl/clkkeep_base_timer_chk.sv
module clkkeep_base_timer_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic             run,
  input logic             wrap_ie,
  input logic             tap_ie,
  input logic             count_clr,
  input logic             wrap_flag_clr,
  input logic             tap_flag_clr,
  input logic             wrap_flag,
  input logic             tap_flag,
  input logic [CNT_W-1:0] cnt
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    count_clr |=> cnt == '0); // R7
  AST_CLR_NO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_clr && !tap_flag) |=> !tap_flag); // R7
  AST_CLR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_clr && !wrap_flag) |=> !wrap_flag); // R7
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !wrap_flag_clr) |=> wrap_flag); // R6
  AST_TAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_flag && !tap_flag_clr) |=> tap_flag); // R6
  AST_WRAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_ie && !wrap_flag) |=> !wrap_flag); // R5
  AST_TAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tap_ie && !tap_flag) |=> !tap_flag); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run || src_sel == 2'b11) && !count_clr) |=> $stable(cnt)); // R9
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_flag) |-> cnt == '0); // R3
endmodule

bind clkkeep_base_timer clkkeep_base_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .run(run),
  .wrap_ie(wrap_ie), .tap_ie(tap_ie), .count_clr(count_clr),
  .wrap_flag_clr(wrap_flag_clr), .tap_flag_clr(tap_flag_clr),
  .wrap_flag(wrap_flag), .tap_flag(tap_flag), .cnt(cnt)
);

// File: tb/test_clkkeep_base_timer.sv
module test_clkkeep_base_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic clk = 0, rst_n = 0;
  logic xtal_tick = 0, sys_tick = 0, pre_tick = 0;
  logic [1:0] src_sel = 0, tap_sel = 0;
  logic run = 0, wrap_ie = 0, tap_ie = 0;
  logic count_clr = 0, wrap_flag_clr = 0, tap_flag_clr = 0;
  logic wrap_flag, tap_flag;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkkeep_base_timer i_clkkeep_base_timer (.*);

  // {src[2], drive[2] (3 = all lines), tap[2], advances[16], exp_tap, exp_wrap}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'd0, 16'd31,    1'b0, 1'b0},  // R4 R2
    {2'd0, 2'd0, 2'd0, 16'd32,    1'b1, 1'b0},
    {2'd1, 2'd1, 2'd1, 16'd127,   1'b0, 1'b0},
    {2'd1, 2'd1, 2'd1, 16'd128,   1'b1, 1'b0},
    {2'd2, 2'd2, 2'd2, 16'd511,   1'b0, 1'b0},
    {2'd2, 2'd2, 2'd2, 16'd512,   1'b1, 1'b0},
    {2'd0, 2'd0, 2'd3, 16'd2047,  1'b0, 1'b0},
    {2'd0, 2'd0, 2'd3, 16'd2048,  1'b1, 1'b0},
    {2'd0, 2'd1, 2'd0, 16'd100,   1'b0, 1'b0},  // R2 wrong line
    {2'd1, 2'd2, 2'd0, 16'd100,   1'b0, 1'b0},
    {2'd2, 2'd0, 2'd0, 16'd100,   1'b0, 1'b0},
    {2'd3, 2'd3, 2'd0, 16'd100,   1'b0, 1'b0},
    {2'd1, 2'd1, 2'd0, 16'd16383, 1'b1, 1'b0},  // R3
    {2'd1, 2'd1, 2'd0, 16'd16384, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic advance(input int n, input logic [1:0] drv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xtal_tick = (drv == 2'd0) || (drv == 2'd3);
      sys_tick  = (drv == 2'd1) || (drv == 2'd3);
      pre_tick  = (drv == 2'd2) || (drv == 2'd3);
    end
    @(negedge clk);
    xtal_tick = 0; sys_tick = 0; pre_tick = 0;
  endtask

  task automatic restart();
    @(negedge clk);
    count_clr = 1; wrap_flag_clr = 1; tap_flag_clr = 1;
    @(negedge clk);
    count_clr = 0; wrap_flag_clr = 0; tap_flag_clr = 0;
  endtask

  task automatic pulse_clr_flags();
    @(negedge clk); wrap_flag_clr = 1; tap_flag_clr = 1;
    @(negedge clk); wrap_flag_clr = 0; tap_flag_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tap_flag reset", tap_flag, 1'b0);
    check("R1 wrap_flag reset", wrap_flag, 1'b0);
    rst_n = 1;
    run = 1; wrap_ie = 1; tap_ie = 1;
    // R1: counter starts at zero: first tap after exactly 32 advances
    advance(31, 2'd0);
    check("R1 no tap before 32", tap_flag, 1'b0);
    advance(1, 2'd0);
    check("R1 tap at 32 from reset", tap_flag, 1'b1);

    for (int v = 0; v < NVEC; v++) begin
      restart();
      src_sel = VEC[v][23:22];
      tap_sel = VEC[v][19:18];
      advance(int'(VEC[v][17:2]), VEC[v][21:20]);
      check($sformatf("R2/R3/R4 vec%0d tap", v), tap_flag, VEC[v][1]);
      check($sformatf("R2/R3/R4 vec%0d wrap", v), wrap_flag, VEC[v][0]);
    end

    src_sel = 2'd1; tap_sel = 2'd0;
    // R6 sticky and clear
    restart();
    advance(32, 2'd1);
    repeat (20) @(negedge clk);
    check("R6 tap sticky", tap_flag, 1'b1);
    pulse_clr_flags();
    check("R6 tap cleared", tap_flag, 1'b0);
    // R6 set wins over coincident clear
    advance(31, 2'd1);
    @(negedge clk); sys_tick = 1; tap_flag_clr = 1;
    @(negedge clk); sys_tick = 0; tap_flag_clr = 0;
    check("R6 set beats clear", tap_flag, 1'b1);

    // R5 disabled flag does not rise
    restart();
    tap_ie = 0;
    advance(32, 2'd1);
    check("R5 tap masked", tap_flag, 1'b0);
    tap_ie = 1;
    advance(32, 2'd1);
    check("R4 repeat after span", tap_flag, 1'b1);

    // R7 clear mid-count restarts, clear beats advance, no flag
    restart();
    advance(20, 2'd1);
    restart();
    advance(31, 2'd1);
    check("R7 restart from zero", tap_flag, 1'b0);
    @(negedge clk); sys_tick = 1; count_clr = 1;
    @(negedge clk); sys_tick = 0; count_clr = 0;
    check("R7 clear raises no flag", tap_flag, 1'b0);
    advance(31, 2'd1);
    check("R7 clear beat advance", tap_flag, 1'b0);
    advance(1, 2'd1);
    check("R7 tap after 32 from clear", tap_flag, 1'b1);

    // R9 run low holds
    restart();
    run = 0;
    advance(100, 2'd1);
    run = 1;
    advance(31, 2'd1);
    check("R9 held while stopped", tap_flag, 1'b0);
    advance(1, 2'd1);
    check("R9 resumes count", tap_flag, 1'b1);

    // R8 wrap keeps running
    restart();
    advance(16384, 2'd1);
    check("R8 first wrap", wrap_flag, 1'b1);
    pulse_clr_flags();
    advance(16383, 2'd1);
    check("R8 not before second wrap", wrap_flag, 1'b0);
    advance(1, 2'd1);
    check("R8 second wrap", wrap_flag, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule